// File: doc/BRIEF.md
# Bus Master Domain Assignment Unit

This unit stands between the bus masters and the access checkers. It tags every transaction with a domain number and with the effective privilege and secure attributes. Each master owns a small bank of assignment descriptors. Each descriptor compares the transaction's input ID bits through a don't-care mask against a match value. The lowest-numbered valid descriptor that hits sets the domain and chooses how each attribute is formed. The attribute can be the master's own signal, or it can be forced low or high. A transaction that hits no descriptor leaves with domain 0 and an "unassigned" flag.

Software programs the descriptors through a simple register port, which reads back without wait states. Setting a descriptor's lock bit freezes that descriptor until reset. The same port holds a two-step global enable. A pending write arms it, and a later commit write makes it take effect. The resulting global-valid level is driven out for the checkers downstream.

Top module: `mda_unit`

## Requirements
- R1: After reset every descriptor word reads 0, the control register reads 0, `globalValid` is 0 and `outValid` is 0.
- R2: A descriptor hits when `(txnId XOR match) AND NOT mask` is zero. Only the descriptors of the master given on `txnMaster` are considered. Descriptor d of master m sits at slot index m*NUM_DESC+d.
- R3: Descriptors whose valid bit is 0 never hit. When several valid descriptors hit, the one with the lowest index supplies the result.
- R4: If no descriptor hits, `outDid` is 0 and `outUnassigned` is 1, and `outPriv`/`outSecure` equal the master's own `txnPriv`/`txnSecure`.
- R5: Each attribute code is 2 bits. Codes 2'b00 and 2'b01 pass the master's signal through, 2'b10 forces 0 and 2'b11 forces 1.
- R6: A write to word 1 with bit 31 set stores its fields and locks the descriptor. Later writes to either word of that descriptor are ignored. Only reset clears the lock.
- R7: The control register is at address bit ADDR_W-1 = 1. Bit 0 is the pending bit and bit 1 is the commit bit. Writing 2'b01 arms pending. Writing 2'b11 sets `globalValid` only if pending was already armed; otherwise it only arms pending. Writing 2'b10 is ignored. A read returns {globalValid, pending} in bits [1:0].
- R8: Writing 2'b00 to the control register clears both pending and `globalValid`.
- R9: Results appear one clock after the transaction is presented. `outValid` is the one-cycle-delayed `txnValid`.
- R10: For descriptor access, address bit 0 selects the word and bits [ADDR_W-2:1] select the slot. Word 0 holds the mask in bits [ID_W-1:0] and the match in bits [16+ID_W-1:16]. Word 1 holds the domain in [DID_W-1:0], the privilege code in [9:8], the secure code in [13:12], valid in bit 30 and lock in bit 31. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | $clog2(NUM_MASTERS*NUM_DESC)+2 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| txnValid | input | 1 | Transaction present |
| txnMaster | input | $clog2(NUM_MASTERS) | Master number |
| txnId | input | ID_W | Transaction input ID bits |
| txnPriv | input | 1 | Master's own privilege attribute |
| txnSecure | input | 1 | Master's own secure attribute |
| outValid | output | 1 | Result present |
| outDid | output | DID_W | Assigned domain |
| outPriv | output | 1 | Effective privilege attribute |
| outSecure | output | 1 | Effective secure attribute |
| outUnassigned | output | 1 | No descriptor hit |
| globalValid | output | 1 | Committed global enable |

## Verification
Directed IDs are chosen to hit through don't-care bits and to miss on a single cared bit. This separates a correct mask polarity from an inverted one. Overlapping descriptors, a catch-all in a higher slot, and an invalid descriptor that would otherwise hit in slot 0 show whether priority and the valid bit are honoured. The same ID is also sent from the other master, which exposes any leakage between descriptor banks. Random writes and random IDs follow, many of them built from a stored match value, so hits and misses both occur often. Lock attempts are followed by readback and a reset, and the control-register write sequences cover commit-before-pending as well as clearing.

// File: rtl/mda_pkg.sv
package mda_pkg;
  // Field positions inside the two descriptor words
  localparam int W0_MATCH_LSB = 16;
  localparam int W1_PRIV_LSB  = 8;
  localparam int W1_SEC_LSB   = 12;
  localparam int W1_VALID_BIT = 30;
  localparam int W1_LOCK_BIT  = 31;

  typedef enum logic [1:0] {
    ATTR_PASS    = 2'b00,
    ATTR_PASS_B  = 2'b01,
    ATTR_FORCE0  = 2'b10,
    ATTR_FORCE1  = 2'b11
  } attr_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrW0;
    logic wrW1;
  } desc_strobe_t;

  function automatic logic resolveAttr(logic [1:0] code, logic own);
    case (attr_mode_e'(code))
      ATTR_FORCE0: return 1'b0;
      ATTR_FORCE1: return 1'b1;
      default:     return own;
    endcase
  endfunction
endpackage

// File: rtl/mda_ctrl.sv
module mda_ctrl
  import mda_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [SLOT_W+1:0]    regAddr,
  input  logic [1:0]           ctrlBits,
  input  logic [31:0]          descWord,
  input  logic [NUM_SLOTS-1:0] lockVec,
  output desc_strobe_t         strobe,
  output logic [SLOT_W-1:0]    slotSel,
  output logic                 rdHi,
  output logic [31:0]          regRdata,
  output logic                 globalValid
);
  logic isCtrl;
  logic slotLocked;
  logic pendQ;
  logic gvQ;

  assign isCtrl     = regAddr[SLOT_W+1];
  assign slotSel    = regAddr[SLOT_W:1];
  assign rdHi       = regAddr[0];
  assign slotLocked = lockVec[slotSel];

  // Writes to a locked descriptor never reach the datapath
  always_comb begin
    strobe.wrW0 = regWe && !isCtrl && !slotLocked && !rdHi;
    strobe.wrW1 = regWe && !isCtrl && !slotLocked && rdHi;
  end

  // Two-step global enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      gvQ   <= 1'b0;
    end else if (regWe && isCtrl) begin
      if (ctrlBits == 2'b00) begin
        pendQ <= 1'b0;
        gvQ   <= 1'b0;
      end else if (ctrlBits == 2'b11 && pendQ) begin
        gvQ <= 1'b1;
      end else if (ctrlBits[0]) begin
        pendQ <= 1'b1;
      end
    end
  end

  assign globalValid = gvQ;
  assign regRdata    = isCtrl ? {30'b0, gvQ, pendQ} : descWord;

  assert_commit_needs_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gvQ) |-> $past(pendQ));
  assert_valid_implies_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    gvQ |-> pendQ);
  assert_clear_both_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && isCtrl && ctrlBits == 2'b00) |=> (!gvQ && !pendQ));
endmodule

// File: rtl/mda_datapath.sv
module mda_datapath
  import mda_pkg::*;
#(
  parameter int NUM_MASTERS = 2,
  parameter int NUM_DESC    = 4,
  parameter int ID_W        = 8,
  parameter int DID_W       = 4,
  parameter int NUM_SLOTS   = NUM_MASTERS * NUM_DESC,
  parameter int SLOT_W      = $clog2(NUM_SLOTS),
  parameter int MST_W       = $clog2(NUM_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  desc_strobe_t         strobe,
  input  logic [SLOT_W-1:0]    slotSel,
  input  logic                 rdHi,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdWord,
  output logic [NUM_SLOTS-1:0] lockVec,
  input  logic                 txnValid,
  input  logic [MST_W-1:0]     txnMaster,
  input  logic [ID_W-1:0]      txnId,
  input  logic                 txnPriv,
  input  logic                 txnSecure,
  output logic                 outValid,
  output logic [DID_W-1:0]     outDid,
  output logic                 outPriv,
  output logic                 outSecure,
  output logic                 outUnassigned
);
  localparam logic [31:0] ID_ONES  = (32'd1 << ID_W) - 32'd1;
  localparam logic [31:0] W0_KEEP  = ID_ONES | (ID_ONES << W0_MATCH_LSB);
  localparam logic [31:0] W1_KEEP  = ((32'd1 << DID_W) - 32'd1)
                                   | (32'd3 << W1_PRIV_LSB) | (32'd3 << W1_SEC_LSB)
                                   | (32'd1 << W1_VALID_BIT) | (32'd1 << W1_LOCK_BIT);

  logic [31:0] word0Q [NUM_SLOTS];
  logic [31:0] word1Q [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        word0Q[s] <= '0;
        word1Q[s] <= '0;
      end else begin
        if (strobe.wrW0 && slotSel == SLOT_W'(s)) word0Q[s] <= wrData & W0_KEEP;
        if (strobe.wrW1 && slotSel == SLOT_W'(s)) word1Q[s] <= wrData & W1_KEEP;
      end
    end
    assign lockVec[s] = word1Q[s][W1_LOCK_BIT];

    assert_lock_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
      lockVec[s] |=> (lockVec[s] && $stable(word0Q[s]) && $stable(word1Q[s])));
  end

  assign rdWord = rdHi ? word1Q[slotSel] : word0Q[slotSel];

  // Priority search: walk downward so the lowest hit overrides
  logic        hit;
  logic [31:0] hitW1;
  always_comb begin
    hit   = 1'b0;
    hitW1 = '0;
    for (int d = NUM_DESC - 1; d >= 0; d--) begin
      int idx;
      logic [ID_W-1:0] dMask;
      logic [ID_W-1:0] dMatch;
      idx    = int'(txnMaster) * NUM_DESC + d;
      dMask  = word0Q[idx][ID_W-1:0];
      dMatch = word0Q[idx][W0_MATCH_LSB +: ID_W];
      if (word1Q[idx][W1_VALID_BIT] && (((txnId ^ dMatch) & ~dMask) == '0)) begin
        hit   = 1'b1;
        hitW1 = word1Q[idx];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      outDid        <= '0;
      outPriv       <= 1'b0;
      outSecure     <= 1'b0;
      outUnassigned <= 1'b0;
    end else begin
      outValid      <= txnValid;
      outDid        <= (txnValid && hit) ? hitW1[DID_W-1:0] : '0;
      outPriv       <= !txnValid ? 1'b0 :
                       hit ? resolveAttr(hitW1[W1_PRIV_LSB +: 2], txnPriv) : txnPriv;
      outSecure     <= !txnValid ? 1'b0 :
                       hit ? resolveAttr(hitW1[W1_SEC_LSB +: 2], txnSecure) : txnSecure;
      outUnassigned <= txnValid && !hit;
    end
  end

  assert_no_locked_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrW0 || strobe.wrW1) |-> !lockVec[slotSel]);
  assert_one_word_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrW0, strobe.wrW1}));
  assert_unassigned_did_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outUnassigned) |-> outDid == '0);
  assert_latency_on_R9: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |=> outValid);
  assert_latency_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !txnValid |=> !outValid);
endmodule

// File: rtl/mda_unit.sv
module mda_unit
  import mda_pkg::*;
#(
  parameter int NUM_MASTERS = 2,
  parameter int NUM_DESC    = 4,
  parameter int ID_W        = 8,
  parameter int DID_W       = 4
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     regWe,
  input  logic [$clog2(NUM_MASTERS*NUM_DESC)+1:0]  regAddr,
  input  logic [31:0]                              regWdata,
  output logic [31:0]                              regRdata,
  input  logic                                     txnValid,
  input  logic [$clog2(NUM_MASTERS)-1:0]           txnMaster,
  input  logic [ID_W-1:0]                          txnId,
  input  logic                                     txnPriv,
  input  logic                                     txnSecure,
  output logic                                     outValid,
  output logic [DID_W-1:0]                         outDid,
  output logic                                     outPriv,
  output logic                                     outSecure,
  output logic                                     outUnassigned,
  output logic                                     globalValid
);
  // NUM_MASTERS and NUM_DESC are powers of two, NUM_MASTERS >= 2
  localparam int NUM_SLOTS = NUM_MASTERS * NUM_DESC;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  desc_strobe_t          strobe;
  logic [SLOT_W-1:0]     slotSel;
  logic                  rdHi;
  logic [31:0]           descWord;
  logic [NUM_SLOTS-1:0]  lockVec;

  mda_ctrl #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .ctrlBits(regWdata[1:0]), .descWord(descWord), .lockVec(lockVec),
    .strobe(strobe), .slotSel(slotSel), .rdHi(rdHi),
    .regRdata(regRdata), .globalValid(globalValid)
  );

  mda_datapath #(.NUM_MASTERS(NUM_MASTERS), .NUM_DESC(NUM_DESC),
                 .ID_W(ID_W), .DID_W(DID_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotSel(slotSel), .rdHi(rdHi),
    .wrData(regWdata), .rdWord(descWord), .lockVec(lockVec),
    .txnValid(txnValid), .txnMaster(txnMaster), .txnId(txnId),
    .txnPriv(txnPriv), .txnSecure(txnSecure),
    .outValid(outValid), .outDid(outDid), .outPriv(outPriv),
    .outSecure(outSecure), .outUnassigned(outUnassigned)
  );
endmodule

// File: tb/test_mda_unit.sv
`timescale 1ns/1ps
module test_mda_unit;
  localparam logic [31:0] W0K = 32'h00FF_00FF;
  localparam logic [31:0] W1K = 32'hC000_330F;
  localparam logic [4:0]  CTRL = 5'b10000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [4:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic txnValid = 1'b0;
  logic txnMaster = 1'b0;
  logic [7:0] txnId = '0;
  logic txnPriv = 1'b0;
  logic txnSecure = 1'b0;
  logic outValid, outPriv, outSecure, outUnassigned, globalValid;
  logic [3:0] outDid;

  int nChecks = 0;
  int nFails = 0;

  logic [31:0] mW0 [8];
  logic [31:0] mW1 [8];
  logic mPend, mGv;

  always #5 clk = ~clk;

  mda_unit i_mda_unit (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .txnValid(txnValid), .txnMaster(txnMaster), .txnId(txnId),
    .txnPriv(txnPriv), .txnSecure(txnSecure), .outValid(outValid), .outDid(outDid),
    .outPriv(outPriv), .outSecure(outSecure), .outUnassigned(outUnassigned),
    .globalValid(globalValid)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int s = 0; s < 8; s++) begin mW0[s] = '0; mW1[s] = '0; end
    mPend = 1'b0; mGv = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  function automatic logic attrOf(logic [1:0] code, logic own);
    if (code == 2'b10) return 1'b0;
    if (code == 2'b11) return 1'b1;
    return own;
  endfunction

  // Expected {unassigned, secure, priv, did}
  function automatic logic [6:0] expTxn(int m, logic [7:0] id, logic p, logic s);
    for (int d = 0; d < 4; d++) begin
      logic [31:0] w0 = mW0[m*4+d];
      logic [31:0] w1 = mW1[m*4+d];
      if (w1[30] && (((id ^ w0[23:16]) & ~w0[7:0]) == 8'h00))
        return {1'b0, attrOf(w1[13:12], s), attrOf(w1[9:8], p), w1[3:0]};
    end
    return {1'b1, s, p, 4'h0};
  endfunction

  task automatic regWrite(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    if (a[4]) begin
      if (d[1:0] == 2'b00) begin mPend = 1'b0; mGv = 1'b0; end
      else if (d[1:0] == 2'b11 && mPend) mGv = 1'b1;
      else if (d[0]) mPend = 1'b1;
    end else if (!mW1[a[3:1]][31]) begin
      if (a[0]) mW1[a[3:1]] = d & W1K;
      else      mW0[a[3:1]] = d & W0K;
    end
  endtask

  task automatic regCheck(string req, logic [4:0] a);
    logic [31:0] e;
    @(negedge clk);
    regAddr = a;
    #1;
    if (a[4]) e = {30'b0, mGv, mPend};
    else e = a[0] ? mW1[a[3:1]] : mW0[a[3:1]];
    check(req, regRdata, e);
  endtask

  task automatic txnCheck(string req, logic m, logic [7:0] id, logic p, logic s);
    @(negedge clk);
    txnValid = 1'b1; txnMaster = m; txnId = id; txnPriv = p; txnSecure = s;
    @(negedge clk);
    check({req, " R9 valid"}, {31'b0, outValid}, 32'd1);
    check(req, {25'b0, outUnassigned, outSecure, outPriv, outDid},
          {25'b0, expTxn(int'(m), id, p, s)});
    txnValid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    modelReset();
    doReset();

    // R1 reset state
    check("R1 outValid", {31'b0, outValid}, 32'd0);
    check("R1 globalValid", {31'b0, globalValid}, 32'd0);
    for (int a = 0; a < 16; a++) regCheck("R1 desc word", 5'(a));
    regCheck("R1 ctrl", CTRL);
    txnCheck("R4 after reset", 1'b0, 8'h5A, 1'b1, 1'b0);

    // R2 mask/match, R5 force codes: m0 d1 mask 0x0F match 0xA0 did 5 priv=1 sec=0
    regWrite(5'b00010, 32'h00A0_000F);
    regWrite(5'b00011, 32'h4000_2305);
    txnCheck("R2 hit via dont-care", 1'b0, 8'hA7, 1'b0, 1'b1);
    txnCheck("R2 miss on cared bit", 1'b0, 8'hB7, 1'b0, 1'b1);
    txnCheck("R2 other master", 1'b1, 8'hA7, 1'b1, 1'b1);
    regCheck("R10 word0 layout", 5'b00010);
    regCheck("R10 word1 layout", 5'b00011);
    regWrite(5'b00011, 32'hFFFF_FFFF & ~32'hC000_0000 | 32'h4000_0000);
    regCheck("R10 unused bits read 0", 5'b00011);
    regWrite(5'b00011, 32'h4000_2305);

    // R3 priority: d3 catch-all, d0 invalid catch-all
    regWrite(5'b00110, 32'h0000_00FF);
    regWrite(5'b00111, 32'h4000_0009);
    regWrite(5'b00000, 32'h0000_00FF);
    regWrite(5'b00001, 32'h0000_000C);
    txnCheck("R3 lowest wins", 1'b0, 8'hA3, 1'b1, 1'b1);
    txnCheck("R3 catch-all and invalid skipped", 1'b0, 8'h11, 1'b1, 1'b0);

    // R5 pass codes on master 1: priv code 01, sec code 00
    regWrite(5'b01000, 32'h0033_0000);
    regWrite(5'b01001, 32'h4000_0102);
    txnCheck("R5 pass 01/00", 1'b1, 8'h33, 1'b1, 1'b0);
    txnCheck("R5 pass 01/00 b", 1'b1, 8'h33, 1'b0, 1'b1);
    regWrite(5'b01001, 32'h4000_3202);
    txnCheck("R5 force1/force0", 1'b1, 8'h33, 1'b0, 1'b1);

    // R6 lock m1 d2
    regWrite(5'b01100, 32'h0044_0003);
    regWrite(5'b01101, 32'hC000_0007);
    regWrite(5'b01100, 32'h0000_00FF);
    regWrite(5'b01101, 32'h4000_000E);
    regCheck("R6 locked word0", 5'b01100);
    regCheck("R6 locked word1", 5'b01101);
    txnCheck("R6 locked desc still used", 1'b1, 8'h46, 1'b0, 1'b0);

    // R7 / R8 global enable
    regWrite(CTRL, 32'h2);
    regCheck("R7 commit without pending", CTRL);
    regWrite(CTRL, 32'h3);
    regCheck("R7 first 11 only arms", CTRL);
    check("R7 not yet valid", {31'b0, globalValid}, 32'd0);
    regWrite(CTRL, 32'h3);
    check("R7 commit after pending", {31'b0, globalValid}, 32'd1);
    regCheck("R7 readback", CTRL);
    regWrite(CTRL, 32'h0);
    check("R8 cleared", {31'b0, globalValid}, 32'd0);
    regCheck("R8 readback", CTRL);
    regWrite(CTRL, 32'h1);
    regWrite(CTRL, 32'h3);
    check("R7 01 then 11", {31'b0, globalValid}, 32'd1);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int kind = int'($urandom % 4);
      if (kind == 0) begin
        logic [31:0] d = $urandom;
        logic [4:0] a = 5'($urandom % 16);
        if (($urandom % 16) != 0) d[31] = 1'b0;
        regWrite(a, d);
        regCheck("R10 random readback", a);
      end else begin
        logic m = 1'($urandom % 2);
        logic [7:0] id = 8'($urandom);
        if (kind == 1) begin
          logic [31:0] w0 = mW0[int'(m)*4 + int'($urandom % 4)];
          id = (w0[23:16] & ~w0[7:0]) | (id & w0[7:0]);
        end
        txnCheck("R2 R3 R4 R5 random", m, id, 1'($urandom), 1'($urandom));
      end
    end

    // Reset clears locks and global state
    doReset();
    regCheck("R6 lock cleared by reset", 5'b01101);
    regCheck("R1 ctrl after reset", CTRL);
    regWrite(5'b01100, 32'h0011_0000);
    regCheck("R6 writable after reset", 5'b01100);
    @(negedge clk);
    check("R9 idle outValid", {31'b0, outValid}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule